// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Pin Override

This block controls a byte-wide bank of general-purpose I/O pins. Software reaches three registers over a simple word-addressed register bus. The first holds the levels to drive, the second shows the levels seen on the pins, and the third picks each pin's direction. Each pin connects to a pad through an input, an output value and an output enable.

Two kinds of on-chip peripheral can take a pin over without software touching the direction register. A routed SPI supplies its own direction and output level for every pin it enables. A serial transmit line forces its pin to drive, and a serial receive line forces its pin to float. When the peripheral lets go, the stored direction bit controls the pin again.

Pin levels pass through a two-flop synchronizer before software can read them. The last synchronizer flop is the input register. It reads as zero for the first two bus clocks after reset is released.

Top module: `gpio_ovr_port`

## Requirements
- R1: During and after reset the output-data and direction registers hold all zeros. With no peripheral enabled, every pad output enable is therefore 0.
- R2: Register offsets are 0 for output data, 1 for pin input and 2 for direction. Offsets 0 and 2 accept writes and read back the written byte in the cycle after the write. Offset 3 reads as zero, and a write to it changes nothing.
- R3: The input register reads zero at reset release and after the first rising edge that follows. From the second rising edge onward it shows the pad level sampled two edges earlier.
- R4: A write to offset 1 has no effect. The input, output-data and direction values read back unchanged afterwards.
- R5: The input register shows the pad level even on pins whose output enable is 1.
- R6: When the SPI enable bit of a pin is 1, that pin's output enable equals the SPI direction bit (1 = drive) and its output equals the SPI data bit. This holds whatever the direction register and the serial enables say.
- R7: When a pin's transmit enable is 1 and its SPI enable is 0, the pin's output enable is 1 and its output equals the transmit data bit.
- R8: When a pin's receive enable is 1 and both its SPI and transmit enables are 0, the pin's output enable is 0.
- R9: Peripheral overrides never change the stored direction bits. Once all enables of a pin drop to 0, the direction bit controls that pin again.
- R10: A pin with no peripheral enabled takes its output enable from its direction bit (0 = input, 1 = output) and its output from its output-data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register word offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 8 | Levels seen at the pads |
| pad_out | output | 8 | Levels to drive at the pads |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| spi_en | input | 8 | SPI owns pin, per pin |
| spi_dir | input | 8 | SPI direction per pin, 1 = drive |
| spi_dout | input | 8 | SPI output level per pin |
| uart_tx_en | input | 8 | Serial transmit owns pin, per pin |
| uart_tx_dout | input | 8 | Serial transmit level per pin |
| uart_rx_en | input | 8 | Serial receive owns pin, per pin |

## Verification
The bench reads the input register at reset release and after the first and second rising edges. A synchronizer that is one flop short or one flop long shows the pad value one cycle early or one cycle late. It then places the SPI, transmit and receive claims together on single pins, some of them against a set direction bit. A design with the wrong priority drives a pin that should float, or the reverse. After the overrides drop, it reads the direction register back and checks the output enables. A design that wrote the forced direction into the register would leave pins stuck in the peripheral's direction. Writes to the input register and to the unmapped offset are checked by reading every register back, which catches decodes that alias onto a neighbour.

// File: rtl/gpio_ovr_pkg.sv
// Package: shared register offsets and bus width for the GPIO override port.
// Assumes a two-bit word-addressed register bus.
package gpio_ovr_pkg;
    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_ODR  = 2'd0,
        REG_IN   = 2'd1,
        REG_DDR  = 2'd2,
        REG_NONE = 2'd3
    } port_reg_e;
endpackage

// File: rtl/gpio_in_sampler.sv
// Module: gpio_in_sampler
// Synchronizes pad levels through STAGES flops. The last flop is the
// software-visible input register. Every flop resets to zero, so the
// register reads zero until STAGES edges after reset release.
// Assumes STAGES >= 2.
module gpio_in_sampler #(
    parameter int unsigned PORT_W = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] in_q
);
    logic [PORT_W-1:0] stg_q [STAGES];

    // Shift the pad levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
        end else begin
            stg_q[0] <= pad_in;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign in_q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
// Module: gpio_port_regs
// Holds the output-data and direction registers and decodes writes and reads.
// Writes to the input offset and the unused offset are dropped.
// The read path is combinational from bus_addr.
module gpio_port_regs
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned PORT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_we,
    input  logic [PORT_W-1:0]     bus_wdata,
    input  logic [PORT_W-1:0]     in_q,
    output logic [PORT_W-1:0]     bus_rdata,
    output logic [PORT_W-1:0]     odr_q,
    output logic [PORT_W-1:0]     ddr_q
);
    port_reg_e sel;
    assign sel = port_reg_e'(bus_addr);

    // Capture writes to the output-data register.
    always_ff @(posedge clk) begin
        if (!rst_n)                         odr_q <= '0;
        else if (bus_we && sel == REG_ODR)  odr_q <= bus_wdata;
    end

    // Capture writes to the direction register.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ddr_q <= '0;
        else if (bus_we && sel == REG_DDR)  ddr_q <= bus_wdata;
    end

    // Select the read data for the addressed register.
    always_comb begin
        unique case (sel)
            REG_ODR: bus_rdata = odr_q;
            REG_IN:  bus_rdata = in_q;
            REG_DDR: bus_rdata = ddr_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_route.sv
// Module: gpio_pin_route
// Resolves who owns one pin and drives its pad controls. Priority, highest
// first: SPI, serial transmit, serial receive, then the port registers.
// Purely combinational. It never feeds back into the stored direction bit.
module gpio_pin_route (
    input  logic spi_en,
    input  logic spi_dir,
    input  logic spi_dout,
    input  logic tx_en,
    input  logic tx_dout,
    input  logic rx_en,
    input  logic ddr_bit,
    input  logic odr_bit,
    output logic pad_oe,
    output logic pad_out
);
    // Pick the owner of the pin and take direction and level from it.
    always_comb begin
        if (spi_en) begin
            pad_oe  = spi_dir;
            pad_out = spi_dout;
        end else if (tx_en) begin
            pad_oe  = 1'b1;
            pad_out = tx_dout;
        end else if (rx_en) begin
            pad_oe  = 1'b0;
            pad_out = odr_bit;
        end else begin
            pad_oe  = ddr_bit;
            pad_out = odr_bit;
        end
    end
endmodule

// File: rtl/gpio_ovr_port.sv
// Module: gpio_ovr_port (top)
// Byte-wide GPIO port with register bus access and per-pin peripheral override.
// Assumes every enable and pad input is synchronous or quasi-static, except
// pad_in, which is synchronized inside the block.
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_we,
    input  logic [PORT_W-1:0]     bus_wdata,
    output logic [PORT_W-1:0]     bus_rdata,
    input  logic [PORT_W-1:0]     pad_in,
    output logic [PORT_W-1:0]     pad_out,
    output logic [PORT_W-1:0]     pad_oe,
    input  logic [PORT_W-1:0]     spi_en,
    input  logic [PORT_W-1:0]     spi_dir,
    input  logic [PORT_W-1:0]     spi_dout,
    input  logic [PORT_W-1:0]     uart_tx_en,
    input  logic [PORT_W-1:0]     uart_tx_dout,
    input  logic [PORT_W-1:0]     uart_rx_en
);
    logic [PORT_W-1:0] in_q;
    logic [PORT_W-1:0] odr_q;
    logic [PORT_W-1:0] ddr_q;

    gpio_in_sampler #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .in_q   (in_q)
    );

    gpio_port_regs #(.PORT_W(PORT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .in_q      (in_q),
        .bus_rdata (bus_rdata),
        .odr_q     (odr_q),
        .ddr_q     (ddr_q)
    );

    for (genvar p = 0; p < PORT_W; p++) begin : g_pin
        gpio_pin_route u_route (
            .spi_en   (spi_en[p]),
            .spi_dir  (spi_dir[p]),
            .spi_dout (spi_dout[p]),
            .tx_en    (uart_tx_en[p]),
            .tx_dout  (uart_tx_dout[p]),
            .rx_en    (uart_rx_en[p]),
            .ddr_bit  (ddr_q[p]),
            .odr_bit  (odr_q[p]),
            .pad_oe   (pad_oe[p]),
            .pad_out  (pad_out[p])
        );
    end
endmodule

// File: rtl/gpio_ovr_port_chk.sv
// Module: gpio_ovr_port_chk
// Property checker for gpio_ovr_port, attached through bind below.
// Assumes SYNC_STAGES = 2, the only latency the input checks cover.
module gpio_ovr_port_chk
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned PORT_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic                  bus_we,
    input logic [PORT_W-1:0]     bus_rdata,
    input logic [PORT_W-1:0]     pad_in,
    input logic [PORT_W-1:0]     pad_oe,
    input logic [PORT_W-1:0]     spi_en,
    input logic [PORT_W-1:0]     spi_dir,
    input logic [PORT_W-1:0]     uart_tx_en,
    input logic [PORT_W-1:0]     uart_rx_en,
    input logic [PORT_W-1:0]     ddr_q
);
    logic [1:0] since_rst;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_IN_ZERO_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 2'd2 && bus_addr == REG_IN) |-> bus_rdata == '0); // R3

    AST_IN_TRACKS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && bus_addr == REG_IN) |-> bus_rdata == $past(pad_in, 2)); // R5

    AST_SPI_SETS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ spi_dir) & spi_en) == '0); // R6

    AST_TX_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_tx_en & ~spi_en & ~pad_oe) == '0); // R7

    AST_RX_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_rx_en & ~uart_tx_en & ~spi_en & pad_oe) == '0); // R8

    AST_DDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == REG_DDR) |=> $stable(ddr_q)); // R9
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.PORT_W(PORT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .pad_in     (pad_in),
    .pad_oe     (pad_oe),
    .spi_en     (spi_en),
    .spi_dir    (spi_dir),
    .uart_tx_en (uart_tx_en),
    .uart_rx_en (uart_rx_en),
    .ddr_q      (ddr_q)
);

// File: tb/sim_gpio_ovr_port.sv
// Directed bench for gpio_ovr_port. Inputs change on falling edges and
// outputs are sampled 1 time unit after each change.
module sim_gpio_ovr_port;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out, pad_oe;
    logic [W-1:0] spi_en = '0, spi_dir = '0, spi_dout = '0;
    logic [W-1:0] uart_tx_en = '0, uart_tx_dout = '0, uart_rx_en = '0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_ovr_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .spi_en(spi_en), .spi_dir(spi_dir),
        .spi_dout(spi_dout), .uart_tx_en(uart_tx_en), .uart_tx_dout(uart_tx_dout),
        .uart_rx_en(uart_rx_en)
    );

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Reference pad controls, worked out from R6, R7, R8 and R10.
    function automatic logic [W-1:0] exp_oe(input logic [W-1:0] ddr);
        for (int p = 0; p < W; p++)
            exp_oe[p] = spi_en[p] ? spi_dir[p] : uart_tx_en[p] ? 1'b1 :
                        uart_rx_en[p] ? 1'b0 : ddr[p];
    endfunction

    function automatic logic [W-1:0] exp_out(input logic [W-1:0] odr);
        for (int p = 0; p < W; p++)
            exp_out[p] = spi_en[p] ? spi_dout[p] : uart_tx_en[p] ? uart_tx_dout[p] : odr[p];
    endfunction

    task automatic t_reset();
        logic [W-1:0] v;
        pad_in = 8'hA5;
        repeat (3) @(negedge clk);
        rd(2'd0, v); chk("R1 odr reset", v, 8'h00);
        rd(2'd2, v); chk("R1 ddr reset", v, 8'h00);
        chk("R1 oe reset", pad_oe, 8'h00);
        rst_n = 1'b1;
        rd(2'd1, v); chk("R3 in at release", v, 8'h00);
        @(negedge clk);
        rd(2'd1, v); chk("R3 in after one edge", v, 8'h00);
        @(negedge clk);
        rd(2'd1, v); chk("R3 in after two edges", v, 8'hA5);
        pad_in = 8'h3C;
        @(negedge clk);
        rd(2'd1, v); chk("R3 in one edge after change", v, 8'hA5);
        @(negedge clk);
        rd(2'd1, v); chk("R3 in two edges after change", v, 8'h3C);
    endtask

    task automatic t_regs();
        logic [W-1:0] v;
        wr(2'd2, 8'h0F);
        wr(2'd0, 8'hA6);
        rd(2'd2, v); chk("R2 ddr readback", v, 8'h0F);
        rd(2'd0, v); chk("R2 odr readback", v, 8'hA6);
        rd(2'd3, v); chk("R2 unmapped reads zero", v, 8'h00);
        wr(2'd3, 8'hFF);
        rd(2'd0, v); chk("R2 odr after unmapped write", v, 8'hA6);
        rd(2'd2, v); chk("R2 ddr after unmapped write", v, 8'h0F);
        rd(2'd3, v); chk("R2 unmapped still zero", v, 8'h00);
    endtask

    task automatic t_in_write();
        logic [W-1:0] v;
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R4 in after write", v, 8'h3C);
        rd(2'd0, v); chk("R4 odr after in write", v, 8'hA6);
        rd(2'd2, v); chk("R4 ddr after in write", v, 8'h0F);
    endtask

    task automatic t_plain();
        #1;
        chk("R10 oe from ddr", pad_oe, 8'h0F);
        chk("R10 out from odr", pad_out, 8'hA6);
    endtask

    task automatic t_in_out();
        logic [W-1:0] v;
        wr(2'd2, 8'hFF);
        wr(2'd0, 8'h00);
        pad_in = 8'h81;
        repeat (2) @(negedge clk);
        chk("R5 all pins driving", pad_oe, 8'hFF);
        rd(2'd1, v); chk("R5 in shows pad on outputs", v, 8'h81);
        wr(2'd2, 8'h0F);
        wr(2'd0, 8'hA6);
    endtask

    task automatic t_spi();
        spi_en = 8'h0F; spi_dir = 8'h05; spi_dout = 8'h0A;
        uart_tx_en = 8'h03; uart_tx_dout = 8'h00; uart_rx_en = 8'h04;
        #1;
        chk("R6 spi oe", pad_oe, exp_oe(8'h0F));
        chk("R6 spi out", pad_out, exp_out(8'hA6));
        chk("R6 spi oe literal", pad_oe & 8'h0F, 8'h05);
        spi_en = '0; uart_tx_en = '0; uart_rx_en = '0;
    endtask

    task automatic t_uart();
        uart_tx_en = 8'h30; uart_tx_dout = 8'h20; uart_rx_en = 8'h21;
        #1;
        chk("R7 tx forces drive", pad_oe & 8'h30, 8'h30);
        chk("R7 tx level", pad_out & 8'h30, 8'h20);
        chk("R8 rx forces input", pad_oe & 8'h01, 8'h00);
        chk("R7 R8 full oe", pad_oe, exp_oe(8'h0F));
        chk("R7 full out", pad_out, exp_out(8'hA6));
    endtask

    task automatic t_ddr_hold();
        logic [W-1:0] v;
        spi_en = 8'hC0; spi_dir = 8'hC0;
        @(negedge clk);
        rd(2'd2, v); chk("R9 ddr kept under override", v, 8'h0F);
        spi_en = '0; uart_tx_en = '0; uart_rx_en = '0;
        @(negedge clk);
        #1;
        chk("R9 ddr governs after release", pad_oe, 8'h0F);
        chk("R9 odr governs after release", pad_out, 8'hA6);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_regs();
        t_in_write();
        t_plain();
        t_in_out();
        t_spi();
        t_uart();
        t_ddr_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule